// File: doc/BRIEF.md
# Serial Flash Command Front-End

This block is the slave-side command interpreter of a small serial flash. It watches the chip-select, serial clock and serial data input pins. It oversamples them with the system clock, so the serial clock may idle low (mode 0) or high (mode 3). The block drives a serial data output together with its output-enable. The first byte after chip select falls is the opcode, sent most significant bit first. The block decodes that opcode as a read-type or a write-type command and then collects any address, dummy or status bytes that follow. For a read-type command it streams bytes from the back end. For a write-type command it checks where the frame ends and sends the back end a one-cycle execute strobe only when the frame ended cleanly.

Page-program data leaves the block as a stream of `wr_valid` / `wr_data` / `wr_addr` beats, one per received byte. The serial master cannot be stalled, so the stream has no back-pressure. The sink must take every beat in the cycle it is valid. A program with no execute strobe at the end of the frame tells the sink to drop the bytes it collected. Read data comes back through `rd_byte`, a combinational function of `rd_addr` and `cur_op`. The block samples it one cycle after it moves `rd_addr`.

Top module: `spif_cmd_frontend`

## Requirements
- R1: `spi_so_oe` is low whenever chip select is high or the block is in standby.
- R2: The block samples `spi_si` on serial-clock rising edges and changes `spi_so` after falling edges, MSB first. It works the same with the clock idling low or idling high.
- R3: An opcode outside the decoded set puts the block in standby. In standby the block ignores every clock and data bit until chip select rises and falls again: no strobe, no output, no state change.
- R4: A write-type command raises `exec_valid` only in these cases:
  - its header is complete, and
  - chip select rises with a bit count that is a multiple of 8.
  In every other case the command is dropped.
- R5: READ (03h) takes a 3-byte address and then returns `rd_byte` for `rd_addr` = address, address+1, and so on. FAST READ (0Bh) does the same after one extra dummy byte.
- R6: READ STATUS (05h) returns the byte {6'b0, write-enable latch, busy} and repeats it for as long as clocks continue.
- R7: While `busy` is high, the array commands (03h, 0Bh, 02h, 20h, D8h, 60h, C7h, 01h) are ignored. Each one drops to standby with no strobe and no output.
- R8: WRITE ENABLE (06h) sets the write-enable latch and WRITE DISABLE (04h) clears it. The commands 02h, 20h, D8h, 60h, C7h and 01h are ignored when the latch is clear, and their accepted strobe clears it.
- R9: `exec_valid` lasts one cycle. It carries `exec_op`, the 24-bit header address `exec_addr`, and `exec_sector` = address bits [15:12].
- R10: Opcode ABh with chip select rising after exactly 8 bits gives an ABh strobe (release from deep power-down). With more clocks, ABh is a read-type signature command with 3 dummy bytes and no strobe.
- R11: Each page-program (02h) data byte gives one `wr_valid` beat. The beat address starts at the header address and its low 8 bits wrap within the page.
- R12: WRITE STATUS (01h) takes one byte, which appears on `exec_data` with the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_csn | input | 1 | Chip select, active low |
| spi_sclk | input | 1 | Serial clock (mode 0 or 3) |
| spi_si | input | 1 | Serial data in |
| spi_so | output | 1 | Serial data out |
| spi_so_oe | output | 1 | Output enable for spi_so (low = high-Z) |
| busy | input | 1 | Back end is programming, erasing or writing status |
| cur_op | output | 8 | Opcode of the current frame |
| rd_addr | output | 24 | Address of the next read byte |
| rd_byte | input | 8 | Read data for rd_addr / cur_op |
| wr_valid | output | 1 | Program data beat valid |
| wr_addr | output | 24 | Program data beat address |
| wr_data | output | 8 | Program data beat byte |
| exec_valid | output | 1 | One-cycle execute strobe |
| exec_op | output | 8 | Opcode being executed |
| exec_addr | output | 24 | Header address of the executed command |
| exec_sector | output | 4 | Sector index of exec_addr |
| exec_data | output | 8 | Status byte for write status |

## Verification
The assertions rely on the serial pins being slow next to `clk`. Each serial-clock phase must last at least three system cycles. Chip select must change at least two cycles away from any serial-clock edge. Under those conditions the strobe always follows a synchronised chip-select rise, and beats never fall on adjacent cycles. The stimulus holds every clock phase for six system cycles and waits a full phase around each chip-select change. It also keeps `busy` constant for the length of each frame, so the latch and gating checks see a stable condition.

// File: rtl/spif_pkg.sv
package spif_pkg;

  localparam logic [7:0] OP_WRSR = 8'h01;
  localparam logic [7:0] OP_PP   = 8'h02;
  localparam logic [7:0] OP_READ = 8'h03;
  localparam logic [7:0] OP_WRDI = 8'h04;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_FAST = 8'h0B;
  localparam logic [7:0] OP_SE   = 8'h20;
  localparam logic [7:0] OP_CE1  = 8'h60;
  localparam logic [7:0] OP_MFID = 8'h90;
  localparam logic [7:0] OP_JID  = 8'h9F;
  localparam logic [7:0] OP_SIG  = 8'hAB;
  localparam logic [7:0] OP_DPD  = 8'hB9;
  localparam logic [7:0] OP_CE2  = 8'hC7;
  localparam logic [7:0] OP_BE   = 8'hD8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_OPC, ST_HDR, ST_DATA, ST_STBY
  } fe_state_t;

  typedef struct packed {
    logic       known;
    logic       is_wr;
    logic [2:0] hdr;
    logic       dummy;
    logic       arr;
    logic       need_wel;
  } op_info_t;

  function automatic op_info_t op_decode(input logic [7:0] op);
    op_info_t i;
    i = '0;
    i.known = 1'b1;
    unique case (op)
      OP_WRSR:         begin i.is_wr = 1; i.hdr = 3'd1; i.arr = 1; i.need_wel = 1; end
      OP_PP, OP_SE,
      OP_BE:           begin i.is_wr = 1; i.hdr = 3'd3; i.arr = 1; i.need_wel = 1; end
      OP_CE1, OP_CE2:  begin i.is_wr = 1; i.arr = 1; i.need_wel = 1; end
      OP_WREN, OP_WRDI,
      OP_DPD:          i.is_wr = 1;
      OP_READ:         begin i.hdr = 3'd3; i.arr = 1; end
      OP_FAST:         begin i.hdr = 3'd4; i.dummy = 1; i.arr = 1; end
      OP_SIG, OP_MFID: i.hdr = 3'd3;
      OP_RDSR, OP_JID: i.hdr = 3'd0;
      default:         i.known = 1'b0;
    endcase
    return i;
  endfunction

endpackage

// File: rtl/spif_pin_sync.sv
module spif_pin_sync #(
  parameter int          N      = 3,
  parameter int          STAGES = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  output logic [N-1:0] dout,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  logic [N-1:0] prev;

  for (genvar p = 0; p < N; p++) begin : g_pin
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain   <= {STAGES{RST_VAL[p]}};
        prev[p] <= RST_VAL[p];
      end else begin
        chain   <= {chain[STAGES-2:0], din[p]};
        prev[p] <= chain[STAGES-1];
      end
    end
    assign dout[p] = chain[STAGES-1];
    assign rise[p] = chain[STAGES-1] & ~prev[p];
    assign fall[p] = ~chain[STAGES-1] & prev[p];
  end
endmodule

// File: rtl/spif_rx.sv
module spif_rx #(
  parameter int BW = 8,
  localparam int CW = $clog2(BW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          en,
  input  logic          si,
  output logic          aligned,
  output logic          byte_done,
  output logic [BW-1:0] byte_q
);
  logic [CW-1:0] cnt;
  logic [BW-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; sh <= '0; byte_done <= 1'b0; byte_q <= '0;
    end else begin
      byte_done <= 1'b0;
      if (clr) begin
        cnt <= '0;
      end else if (en) begin
        sh  <= {sh[BW-2:0], si};
        cnt <= cnt + CW'(1);
        if (cnt == CW'(BW - 1)) begin
          byte_done <= 1'b1;
          byte_q    <= {sh[BW-2:0], si};
        end
      end
    end
  end

  assign aligned = (cnt == '0);
endmodule

// File: rtl/spif_tx.sv
module spif_tx #(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [BW-1:0] ld_val,
  input  logic          shift,
  output logic          so
);
  logic [BW-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh <= '0; so <= 1'b0;
    end else if (load) begin
      sh <= ld_val;
    end else if (shift) begin
      so <= sh[BW-1];
      sh <= {sh[BW-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/spif_cmd_frontend.sv
module spif_cmd_frontend
  import spif_pkg::*;
#(
  parameter int AW       = 24,
  parameter int SECT_LSB = 12,
  parameter int SECT_W   = 4,
  parameter int SYNC     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_csn,
  input  logic              spi_sclk,
  input  logic              spi_si,
  output logic              spi_so,
  output logic              spi_so_oe,
  input  logic              busy,
  output logic [7:0]        cur_op,
  output logic [AW-1:0]     rd_addr,
  input  logic [7:0]        rd_byte,
  output logic              wr_valid,
  output logic [AW-1:0]     wr_addr,
  output logic [7:0]        wr_data,
  output logic              exec_valid,
  output logic [7:0]        exec_op,
  output logic [AW-1:0]     exec_addr,
  output logic [SECT_W-1:0] exec_sector,
  output logic [7:0]        exec_data
);
  localparam int NPIN = 3;

  logic [NPIN-1:0] pin_s, pin_r, pin_f;
  logic csn_s, csn_fall, csn_rise, sck_rise, sck_fall;

  spif_pin_sync #(.N(NPIN), .STAGES(SYNC), .RST_VAL(3'b001)) sync_i (
    .clk(clk), .rst_n(rst_n), .din({spi_si, spi_sclk, spi_csn}),
    .dout(pin_s), .rise(pin_r), .fall(pin_f)
  );
  assign csn_s    = pin_s[0];
  assign csn_fall = pin_f[0];
  assign csn_rise = pin_r[0];
  assign sck_rise = pin_r[1] & ~csn_s;
  assign sck_fall = pin_f[1] & ~csn_s;

  fe_state_t    state;
  logic [7:0]   op;
  logic [2:0]   hdr_left;
  logic [AW-1:0] addr, ptr, nxt_addr;
  logic         wel, ld_pend, aligned, byte_done, stby_w, strobe;
  logic [7:0]   rx_byte, status, ld_val;
  op_info_t     cur, nxt;

  spif_rx #(.BW(8)) rx_i (
    .clk(clk), .rst_n(rst_n), .clr(csn_fall), .en(sck_rise), .si(pin_s[2]),
    .aligned(aligned), .byte_done(byte_done), .byte_q(rx_byte)
  );

  assign status = {6'b0, wel, busy};
  assign ld_val = (op == OP_RDSR) ? status : rd_byte;

  spif_tx #(.BW(8)) tx_i (
    .clk(clk), .rst_n(rst_n), .load(ld_pend), .ld_val(ld_val),
    .shift(sck_fall), .so(spi_so)
  );

  assign cur      = op_decode(op);
  assign nxt      = op_decode(rx_byte);
  assign nxt_addr = (hdr_left > {2'b0, cur.dummy}) ? {addr[AW-9:0], rx_byte} : addr;
  assign stby_w   = (state == ST_STBY);
  // write-type ends on a byte boundary after its header, or signature opcode alone
  assign strobe   = aligned && ((cur.known && cur.is_wr && state == ST_DATA) ||
                    (op == OP_SIG && state == ST_HDR && hdr_left == cur.hdr));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE; op <= '0; hdr_left <= '0; addr <= '0; ptr <= '0;
      wel <= 1'b0; ld_pend <= 1'b0; wr_valid <= 1'b0; wr_addr <= '0; wr_data <= '0;
      exec_valid <= 1'b0; exec_op <= '0; exec_addr <= '0; exec_data <= '0;
    end else begin
      exec_valid <= 1'b0;
      wr_valid   <= 1'b0;
      ld_pend    <= 1'b0;
      if (ld_pend) ptr <= ptr + AW'(1);
      if (csn_fall) begin
        state <= ST_OPC; op <= '0; addr <= '0; ptr <= '0; hdr_left <= '0;
      end else if (csn_rise) begin
        state <= ST_IDLE;
        if (strobe) begin
          exec_valid <= 1'b1;
          exec_op    <= op;
          exec_addr  <= addr;
          exec_data  <= addr[7:0];
          if (op == OP_WREN)      wel <= 1'b1;
          else if (op == OP_WRDI) wel <= 1'b0;
          else if (cur.need_wel)  wel <= 1'b0;
        end
      end else if (byte_done) begin
        unique case (state)
          ST_OPC: begin
            op       <= rx_byte;
            hdr_left <= nxt.hdr;
            if (!nxt.known || (nxt.arr && busy) || (nxt.need_wel && !wel))
              state <= ST_STBY;
            else if (nxt.hdr == 3'd0) begin
              state   <= ST_DATA;
              ld_pend <= ~nxt.is_wr;
            end else
              state <= ST_HDR;
          end
          ST_HDR: begin
            addr     <= nxt_addr;
            hdr_left <= hdr_left - 3'd1;
            if (hdr_left == 3'd1) begin
              state   <= ST_DATA;
              ptr     <= nxt_addr;
              ld_pend <= ~cur.is_wr;
            end
          end
          ST_DATA: begin
            if (!cur.is_wr) ld_pend <= 1'b1;
            if (op == OP_PP) begin
              wr_valid <= 1'b1;
              wr_data  <= rx_byte;
              wr_addr  <= ptr;
              ptr[7:0] <= ptr[7:0] + 8'd1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign spi_so_oe   = (state == ST_DATA) && !cur.is_wr && !csn_s;
  assign cur_op      = op;
  assign rd_addr     = ptr;
  assign exec_sector = exec_addr[SECT_LSB+SECT_W-1:SECT_LSB];
endmodule

// File: rtl/spif_cmd_chk.sv
module spif_cmd_chk
  import spif_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       csn_s,
  input logic       csn_rise,
  input logic       stby_w,
  input logic       spi_so_oe,
  input logic       exec_valid,
  input logic [7:0] exec_op,
  input logic       wel,
  input logic       wr_valid
);
  op_info_t xi;
  assign xi = op_decode(exec_op);

  assert_oe_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    csn_s |-> !spi_so_oe);

  assert_stby_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    stby_w |-> !spi_so_oe);

  assert_exec_on_cs_R4: assert property (@(posedge clk) disable iff (!rst_n)
    exec_valid |-> $past(csn_rise));

  assert_wel_needed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_valid && xi.need_wel) |-> $past(wel));

  assert_exec_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    exec_valid |=> !exec_valid);

  assert_beat_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid);
endmodule

bind spif_cmd_frontend spif_cmd_chk chk_i (
  .clk(clk), .rst_n(rst_n), .csn_s(csn_s), .csn_rise(csn_rise),
  .stby_w(stby_w), .spi_so_oe(spi_so_oe), .exec_valid(exec_valid),
  .exec_op(exec_op), .wel(wel), .wr_valid(wr_valid)
);

// File: tb/spif_cmd_frontend_tb.sv
module spif_cmd_frontend_tb_top;
  localparam int H = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic spi_csn = 1'b1, spi_sclk = 1'b0, spi_si = 1'b0, busy = 1'b0;
  logic spi_so, spi_so_oe, wr_valid, exec_valid;
  logic [7:0] cur_op, rd_byte, wr_data, exec_op, exec_data;
  logic [23:0] rd_addr, wr_addr, exec_addr;
  logic [3:0] exec_sector;

  always #2 clk = ~clk;

  spif_cmd_frontend dut_i (
    .clk(clk), .rst_n(rst_n), .spi_csn(spi_csn), .spi_sclk(spi_sclk),
    .spi_si(spi_si), .spi_so(spi_so), .spi_so_oe(spi_so_oe), .busy(busy),
    .cur_op(cur_op), .rd_addr(rd_addr), .rd_byte(rd_byte),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .exec_valid(exec_valid), .exec_op(exec_op), .exec_addr(exec_addr),
    .exec_sector(exec_sector), .exec_data(exec_data)
  );

  assign rd_byte = rd_addr[7:0] ^ 8'h5A;

  int n_chk = 0, n_bad = 0;
  int ex_cnt = 0, wr_n = 0;
  logic [7:0] wr_log [8];
  logic [23:0] wa_log [8];

  always @(posedge clk) begin
    if (exec_valid) ex_cnt++;
    if (wr_valid && wr_n < 8) begin
      wr_log[wr_n] = wr_data; wa_log[wr_n] = wr_addr; wr_n++;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  logic [7:0] tx_b [8];
  logic [7:0] rx_b [4];
  logic       oe_any;

  task automatic frame(input bit m3, input int nb, input int xb, input int nrd);
    int hb, tot;
    hb = nb * 8 + xb;
    tot = hb + nrd * 8;
    oe_any = 1'b0;
    @(negedge clk);
    spi_sclk = m3;
    repeat (H) @(negedge clk);
    spi_csn = 1'b0;
    repeat (H) @(negedge clk);
    for (int k = 0; k < tot; k++) begin
      spi_sclk = 1'b0;
      spi_si = (k < hb) ? tx_b[k / 8][7 - (k % 8)] : 1'b0;
      repeat (H) @(negedge clk);
      oe_any = oe_any | spi_so_oe;
      if (k >= hb) rx_b[(k - hb) / 8][7 - ((k - hb) % 8)] = spi_so;
      spi_sclk = 1'b1;
      repeat (H) @(negedge clk);
    end
    if (!m3) spi_sclk = 1'b0;
    repeat (H) @(negedge clk);
    spi_csn = 1'b1;
    repeat (3 * H) @(negedge clk);
  endtask

  task automatic op1(input bit m3, input logic [7:0] op);
    tx_b[0] = op;
    frame(m3, 1, 0, 0);
  endtask

  typedef struct packed {
    logic       m3;
    logic       wren;
    logic [7:0] op;
    logic [2:0] nhb;
    logic [2:0] xb;
    logic       exp;
  } vec_t;

  localparam vec_t VEC [12] = '{
    '{1'b0, 1'b0, 8'h06, 3'd0, 3'd0, 1'b1},
    '{1'b1, 1'b0, 8'h04, 3'd0, 3'd0, 1'b1},
    '{1'b1, 1'b0, 8'h06, 3'd0, 3'd3, 1'b0},
    '{1'b0, 1'b1, 8'h20, 3'd3, 3'd0, 1'b1},
    '{1'b1, 1'b1, 8'h20, 3'd3, 3'd5, 1'b0},
    '{1'b0, 1'b0, 8'h04, 3'd0, 3'd0, 1'b1},
    '{1'b0, 1'b0, 8'h60, 3'd0, 3'd0, 1'b0},
    '{1'b1, 1'b1, 8'hC7, 3'd0, 3'd0, 1'b1},
    '{1'b0, 1'b0, 8'hB9, 3'd0, 3'd0, 1'b1},
    '{1'b1, 1'b0, 8'hAB, 3'd0, 3'd0, 1'b1},
    '{1'b0, 1'b1, 8'h02, 3'd3, 3'd0, 1'b1},
    '{1'b1, 1'b1, 8'hD8, 3'd2, 3'd0, 1'b0}
  };

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    int c0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 reset oe", spi_so_oe, 0);
    chk("R9 reset exec", exec_valid, 0);
    chk("R11 reset beat", wr_valid, 0);

    // table walk: write-type frame endings (R4, R8, R10)
    foreach (VEC[i]) begin
      if (VEC[i].wren) op1(VEC[i].m3, 8'h06);
      tx_b[0] = VEC[i].op;
      for (int j = 1; j < 8; j++) tx_b[j] = 8'(j * 17);
      c0 = ex_cnt;
      frame(VEC[i].m3, 1 + int'(VEC[i].nhb), int'(VEC[i].xb), 0);
      chk($sformatf("R4 vec %0d strobe count", i), ex_cnt - c0, VEC[i].exp ? 1 : 0);
      if (VEC[i].exp) chk($sformatf("R9 vec %0d op", i), exec_op, VEC[i].op);
    end

    // R5 / R2 READ mode 0
    op1(1'b0, 8'h04);
    tx_b[0] = 8'h03; tx_b[1] = 8'h00; tx_b[2] = 8'h12; tx_b[3] = 8'h34;
    frame(1'b0, 4, 0, 3);
    chk("R5 read oe", oe_any, 1);
    chk("R2 read b0", rx_b[0], 8'h34 ^ 8'h5A);
    chk("R5 read b1", rx_b[1], 8'h35 ^ 8'h5A);
    chk("R5 read b2", rx_b[2], 8'h36 ^ 8'h5A);
    chk("R1 oe after cs high", spi_so_oe, 0);

    // R5 / R2 FAST READ mode 3
    tx_b[0] = 8'h0B; tx_b[1] = 8'h00; tx_b[2] = 8'h00; tx_b[3] = 8'hF0; tx_b[4] = 8'hEE;
    frame(1'b1, 5, 0, 2);
    chk("R2 fast b0", rx_b[0], 8'hF0 ^ 8'h5A);
    chk("R5 fast b1", rx_b[1], 8'hF1 ^ 8'h5A);

    // R6 status repeats
    op1(1'b0, 8'h06);
    tx_b[0] = 8'h05;
    frame(1'b1, 1, 0, 2);
    chk("R6 status b0", rx_b[0], 8'h02);
    chk("R6 status b1", rx_b[1], 8'h02);

    // R7 busy gating
    busy = 1'b1;
    tx_b[0] = 8'h03; tx_b[1] = 8'h00; tx_b[2] = 8'h00; tx_b[3] = 8'h10;
    frame(1'b0, 4, 0, 1);
    chk("R7 read while busy oe", oe_any, 0);
    tx_b[0] = 8'h20; c0 = ex_cnt;
    frame(1'b0, 4, 0, 0);
    chk("R7 erase while busy strobe", ex_cnt - c0, 0);
    tx_b[0] = 8'h05;
    frame(1'b0, 1, 0, 1);
    chk("R7 status while busy", rx_b[0], 8'h03);
    busy = 1'b0;
    repeat (4) @(negedge clk);

    // R9 sector erase fields, R8 latch clears
    tx_b[0] = 8'h20; tx_b[1] = 8'h00; tx_b[2] = 8'hA1; tx_b[3] = 8'h23; c0 = ex_cnt;
    frame(1'b1, 4, 0, 0);
    chk("R9 se strobe", ex_cnt - c0, 1);
    chk("R9 se addr", exec_addr, 24'h00A123);
    chk("R9 se sector", exec_sector, 4'hA);
    tx_b[0] = 8'h05;
    frame(1'b0, 1, 0, 1);
    chk("R8 latch cleared", rx_b[0], 8'h00);

    // R3 standby after unknown opcode
    tx_b[0] = 8'hFF; tx_b[1] = 8'h06; c0 = ex_cnt;
    frame(1'b1, 2, 0, 1);
    chk("R3 standby oe", oe_any, 0);
    chk("R3 standby strobe", ex_cnt - c0, 0);
    tx_b[0] = 8'h05;
    frame(1'b1, 1, 0, 1);
    chk("R3 latch untouched", rx_b[0], 8'h00);

    // R11 page program beats with page wrap
    op1(1'b0, 8'h06);
    wr_n = 0;
    tx_b[0] = 8'h02; tx_b[1] = 8'h00; tx_b[2] = 8'h12; tx_b[3] = 8'hFE;
    tx_b[4] = 8'hAA; tx_b[5] = 8'hBB; tx_b[6] = 8'hCC; c0 = ex_cnt;
    frame(1'b0, 7, 0, 0);
    chk("R11 beat count", wr_n, 3);
    chk("R11 beat0 data", wr_log[0], 8'hAA);
    chk("R11 beat0 addr", wa_log[0], 24'h0012FE);
    chk("R11 beat1 addr", wa_log[1], 24'h0012FF);
    chk("R11 beat2 wrap", wa_log[2], 24'h001200);
    chk("R11 beat2 data", wr_log[2], 8'hCC);
    chk("R4 program strobe", ex_cnt - c0, 1);

    // R12 write status byte
    op1(1'b1, 8'h06);
    tx_b[0] = 8'h01; tx_b[1] = 8'h3C; c0 = ex_cnt;
    frame(1'b1, 2, 0, 0);
    chk("R12 wrsr strobe", ex_cnt - c0, 1);
    chk("R12 wrsr data", exec_data, 8'h3C);

    // R10 signature read: no strobe, output enabled
    tx_b[0] = 8'hAB; tx_b[1] = 8'h00; tx_b[2] = 8'h00; tx_b[3] = 8'h00; c0 = ex_cnt;
    frame(1'b0, 4, 0, 1);
    chk("R10 signature no strobe", ex_cnt - c0, 0);
    chk("R10 signature oe", oe_any, 1);
    chk("R1 idle oe", spi_so_oe, 0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule